// File: doc/BRIEF.md
# Centered One-Cycle Phasor Estimator

This block turns a stream of signed fixed-point samples, taken by a fixed-rate sampler at N samples per nominal power-system cycle, into a phasor estimate for a reporting instant. It keeps the most recent N samples. When a time mark arrives, it takes a snapshot of that window and computes a one-cycle discrete Fourier sum over it. The window is centred on the mark. The oldest sample in the window has index k = -N/2 and the newest has index k = N/2-1. Sample k is assumed to lie half a sample after k·Δt, and its coefficient angle carries the same half-sample shift, 2π(k+½)/N.

The result is the real and imaginary parts of a cosine-referenced phasor scaled to RMS: a peak amplitude of Xm gives a magnitude of Xm/√2. At nominal frequency the estimate has no gain error and no phase error. Off nominal, the estimate is returned exactly as the sum produces it. The locus of estimates then becomes an ellipse, and the block does no frequency tracking and applies no correction. The caller strobes samples in as they arrive and raises the mark input for one cycle at each reporting instant. A one-cycle valid pulse follows a fixed number of cycles later.

Top module: `phasorEstimator`

## Requirements
- R1: While reset is low, and after its release until the first result, phValid is 0 and phRe and phIm are 0.
- R2: Each cycle with sampleStb high shifts sampleIn into an N-deep window, dropping the oldest sample. An accepted mark uses the N most recent samples; a sample strobed in the same cycle as the accepted mark is not part of that window.
- R3: The accumulators and outputs never wrap: a full-scale input (peak 32767 for W=16) gives a magnitude of about 23170, and every output stays within ±(2^(W-1)·√2).
- R4: For a nominal-frequency input x[k] = round(Xm·cos(2π(k+½)/N + φ)), phRe equals Xm·cos(φ)/√2 and phIm equals Xm·sin(φ)/√2, each within 3 LSB.
- R5: A mark accepted at a clock edge gives phValid high for exactly one cycle, N+2 clock cycles after that edge.
- R6: phRe and phIm change only in the cycle in which phValid is high. Samples strobed between results leave them unchanged.
- R7: A mark is accepted only while the block is idle. A mark raised during the N+2 cycles after an accepted mark, including the cycle in which the block loads its output registers, is ignored and produces no extra pulse.
- R8: Samples strobed while a result is being computed do not change that result.
- R9: A constant (DC) input gives phRe and phIm within 2 LSB of zero.
- R10: For any input, phRe = (√2/N)·Σ x[k]·cos(2π(k+½)/N) and phIm = -(√2/N)·Σ x[k]·sin(2π(k+½)/N), within 3 LSB. No off-nominal correction is applied, so an input at 1.1× nominal frequency gives a result that differs visibly from the true phasor.
- R11: N is even and at least 4. The coefficients are round(32767·cos) and round(-32767·sin) of the half-sample-offset angles, built at elaboration with no external table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | W | Signed input sample |
| sampleStb | input | 1 | Shifts sampleIn into the window |
| markIn | input | 1 | Reporting-instant mark; starts an estimate when idle |
| phRe | output | W+1 | Signed real part of the RMS phasor |
| phIm | output | W+1 | Signed imaginary part of the RMS phasor |
| phValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The output-range property assumes that every sample lies within the signed W-bit range and that the coefficients are bounded by one in Q15. The stimulus keeps to this by building each wave from an amplitude of at most 32767 before rounding. The latency and extra-pulse properties assume that marks reach the block only as single-cycle pulses. They model acceptance with their own counter, which includes the cycle in which the output registers load. The bench places its extra marks both mid-run and in that load cycle. The bench also never strobes a sample in the same cycle as the mark it measures, so that the window boundary in R2 stays well defined.

// File: rtl/phasorPkg.sv
package phasorPkg;

  typedef struct packed {
    logic snap;   // freeze the window and clear the sums
    logic mac;    // accumulate one product pair
    logic scale;  // multiply the sums by the RMS constant
    logic emit;   // round, load the outputs, pulse valid
  } phStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_SCALE = 2'd2,
    PH_EMIT  = 2'd3
  } phState_t;

  localparam real PH_TWO_PI = 6.283185307179586;
  localparam real PH_SQRT2  = 1.4142135623730951;

  function automatic int qRound(real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

endpackage

// File: rtl/phasorCoefRom.sv
module phasorCoefRom
  import phasorPkg::*;
#(
  parameter int N  = 16,
  parameter int CW = 16
) (
  input  logic [$clog2(N)-1:0] idx,
  output logic signed [CW-1:0] cosC,
  output logic signed [CW-1:0] sinNegC
);

  localparam real FS = real'((1 << (CW - 1)) - 1);

  logic signed [CW-1:0] cosTab [N];
  logic signed [CW-1:0] sinTab [N];

  // Entry j belongs to window index k = j - N/2; the angle carries the half-sample shift.
  for (genvar j = 0; j < N; j++) begin : gCoef
    localparam real ANG = PH_TWO_PI * (real'(j) - real'(N / 2) + 0.5) / real'(N);
    localparam logic signed [CW-1:0] CQ = CW'(qRound(FS * $cos(ANG)));
    localparam logic signed [CW-1:0] SQ = CW'(-qRound(FS * $sin(ANG)));
    assign cosTab[j] = CQ;
    assign sinTab[j] = SQ;
  end

  assign cosC    = cosTab[idx];
  assign sinNegC = sinTab[idx];

endmodule

// File: rtl/phasorCtrl.sv
module phasorCtrl
  import phasorPkg::*;
#(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 markIn,
  output phStrobe_t            stb,
  output logic [$clog2(N)-1:0] idx
);

  localparam int IW = $clog2(N);

  phState_t        state;
  logic [IW-1:0]   cnt;

  always_comb begin
    stb       = '0;
    stb.snap  = (state == PH_IDLE) && markIn;
    stb.mac   = (state == PH_RUN);
    stb.scale = (state == PH_SCALE);
    stb.emit  = (state == PH_EMIT);
    idx       = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        PH_IDLE: begin
          cnt <= '0;
          if (markIn) state <= PH_RUN;
        end
        PH_RUN: begin
          if (cnt == IW'(N - 1)) begin
            cnt   <= '0;
            state <= PH_SCALE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SCALE: state <= PH_EMIT;
        default:  state <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phasorDatapath.sv
module phasorDatapath
  import phasorPkg::*;
#(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [W-1:0]  sampleIn,
  input  logic                 sampleStb,
  input  phStrobe_t            stb,
  input  logic [$clog2(N)-1:0] idx,
  input  logic signed [CW-1:0] cosC,
  input  logic signed [CW-1:0] sinNegC,
  output logic signed [W:0]    phRe,
  output logic signed [W:0]    phIm,
  output logic                 phValid
);

  localparam int OW    = W + 1;
  localparam int PW    = W + CW;
  localparam int ACCW  = W + CW + $clog2(N);
  localparam int KW    = 20;
  localparam int SW    = ACCW + KW;
  localparam int SH    = 17 + $clog2(N);
  localparam int TOTSH = CW - 1 + SH;
  localparam int KV    = qRound(PH_SQRT2 * (2.0 ** SH) / real'(N));
  localparam logic signed [KW-1:0] KCONST = KW'(KV);
  localparam logic signed [SW-1:0] RND    = SW'(1) <<< (TOTSH - 1);

  logic signed [W-1:0]    win  [N];
  logic signed [W-1:0]    hold [N];
  logic signed [W-1:0]    curX;
  logic signed [PW-1:0]   prodRe, prodIm;
  logic signed [ACCW-1:0] extRe, extIm;
  logic signed [ACCW-1:0] accRe, accIm;
  logic signed [SW-1:0]   scRe, scIm;

  // Sliding window: index N-1 holds the newest sample.
  for (genvar j = 0; j < N; j++) begin : gWin
    if (j == N - 1) begin : gHead
      always_ff @(posedge clk) begin
        if (!rstN)          win[j] <= '0;
        else if (sampleStb) win[j] <= sampleIn;
      end
    end else begin : gBody
      always_ff @(posedge clk) begin
        if (!rstN)          win[j] <= '0;
        else if (sampleStb) win[j] <= win[j+1];
      end
    end
    always_ff @(posedge clk) begin
      if (!rstN)         hold[j] <= '0;
      else if (stb.snap) hold[j] <= win[j];
    end
  end

  assign curX   = hold[idx];
  assign prodRe = PW'(curX) * PW'(cosC);
  assign prodIm = PW'(curX) * PW'(sinNegC);
  assign extRe  = prodRe;
  assign extIm  = prodIm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accRe <= '0;
      accIm <= '0;
    end else if (stb.snap) begin
      accRe <= '0;
      accIm <= '0;
    end else if (stb.mac) begin
      accRe <= accRe + extRe;
      accIm <= accIm + extIm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scRe <= '0;
      scIm <= '0;
    end else if (stb.scale) begin
      scRe <= SW'(accRe) * SW'(KCONST);
      scIm <= SW'(accIm) * SW'(KCONST);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phRe    <= '0;
      phIm    <= '0;
      phValid <= 1'b0;
    end else begin
      phValid <= stb.emit;
      if (stb.emit) begin
        phRe <= OW'((scRe + RND) >>> TOTSH);
        phIm <= OW'((scIm + RND) >>> TOTSH);
      end
    end
  end

endmodule

// File: rtl/phasorEstimator.sv
module phasorEstimator
  import phasorPkg::*;
#(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic signed [W-1:0] sampleIn,
  input  logic                sampleStb,
  input  logic                markIn,
  output logic signed [W:0]   phRe,
  output logic signed [W:0]   phIm,
  output logic                phValid
);

  // R11: the centred window needs an even count of at least four.
  if ((N % 2) != 0 || N < 4) begin : gBadN
    $error("phasorEstimator: N must be even and at least 4");
  end

  phStrobe_t            stb;
  logic [$clog2(N)-1:0] idx;
  logic signed [CW-1:0] cosC, sinNegC;

  phasorCtrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .markIn (markIn),
    .stb    (stb),
    .idx    (idx)
  );

  phasorCoefRom #(.N(N), .CW(CW)) u_rom (
    .idx     (idx),
    .cosC    (cosC),
    .sinNegC (sinNegC)
  );

  phasorDatapath #(.N(N), .W(W), .CW(CW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sampleIn),
    .sampleStb (sampleStb),
    .stb       (stb),
    .idx       (idx),
    .cosC      (cosC),
    .sinNegC   (sinNegC),
    .phRe      (phRe),
    .phIm      (phIm),
    .phValid   (phValid)
  );

endmodule

// File: rtl/phasorEstimatorChk.sv
module phasorEstimatorChk #(
  parameter int N = 16,
  parameter int W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                markIn,
  input logic signed [W:0]   phRe,
  input logic signed [W:0]   phIm,
  input logic                phValid
);

  localparam int CNTW = $clog2(N + 3) + 1;
  localparam int LIM  = $rtoi((2.0 ** (W - 1)) * 1.4142135623730951) + 1;

  logic            pend;
  logic [CNTW-1:0] cnt;

  // Independent model of mark acceptance and result timing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= 1'b0;
      cnt  <= '0;
    end else if (markIn && (!pend || cnt == CNTW'(N + 2))) begin
      pend <= 1'b1;
      cnt  <= '0;
    end else if (pend) begin
      if (cnt == CNTW'(N + 2)) pend <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pend && cnt == CNTW'(N + 2)) |-> phValid);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    phValid |=> !phValid);

  p_no_stray_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    phValid |-> (pend && cnt == CNTW'(N + 2)));

  p_hold_outputs_r6: assert property (@(posedge clk) disable iff (!rstN)
    !phValid |-> ($stable(phRe) && $stable(phIm)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    phValid |-> (int'(phRe) <= LIM && int'(phRe) >= -LIM &&
                 int'(phIm) <= LIM && int'(phIm) >= -LIM));

endmodule

bind phasorEstimator phasorEstimatorChk #(.N(N), .W(W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .markIn  (markIn),
  .phRe    (phRe),
  .phIm    (phIm),
  .phValid (phValid)
);

// File: tb/phasorEstimator_tb.sv
module phasorEstimator_tb;

  localparam int  CLK_PERIOD = 10;
  localparam int  N  = 16;
  localparam int  W  = 16;
  localparam real TWO_PI = 6.283185307179586;
  localparam real SQ2    = 1.4142135623730951;

  logic                clk = 1'b0;
  logic                rstN;
  logic signed [W-1:0] sampleIn;
  logic                sampleStb;
  logic                markIn;
  logic signed [W:0]   phRe, phIm;
  logic                phValid;

  int total = 0;
  int bad   = 0;
  int lastX [N];
  int gotRe, gotIm;
  real expRe, expIm;

  phasorEstimator #(.N(N), .W(W), .CW(16)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sampleIn),
    .sampleStb (sampleStb),
    .markIn    (markIn),
    .phRe      (phRe),
    .phIm      (phIm),
    .phValid   (phValid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int rnd(real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  task automatic chkNear(string tag, int act, int exp, int tol);
    total++;
    if (act - exp > tol || exp - act > tol) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bench form of the R10 sum over the last window fed in.
  task automatic dftOfWindow();
    expRe = 0.0;
    expIm = 0.0;
    for (int k = 0; k < N; k++) begin
      real a;
      a = TWO_PI * (real'(k - N / 2) + 0.5) / real'(N);
      expRe += real'(lastX[k]) * $cos(a);
      expIm -= real'(lastX[k]) * $sin(a);
    end
    expRe = expRe * SQ2 / real'(N);
    expIm = expIm * SQ2 / real'(N);
  endtask

  task automatic feedWave(real amp, real fr, real ph);
    for (int k = 0; k < N; k++) begin
      real a;
      a = TWO_PI * fr * (real'(k - N / 2) + 0.5) / real'(N) + ph;
      lastX[k]  = rnd(amp * $cos(a));
      sampleIn  = W'(lastX[k]);
      sampleStb = 1'b1;
      @(negedge clk);
    end
    sampleStb = 1'b0;
  endtask

  // Raise a mark, follow the cycles up to the pulse and capture the result.
  // extraAt: loop step at which a second mark is raised (0 = none).
  task automatic runMark(string tag, int extraAt, bit feedDuring);
    bit okT;
    okT    = 1'b1;
    markIn = 1'b1;
    @(negedge clk);
    for (int m = 1; m <= N + 3; m++) begin
      markIn    = (m == extraAt);
      sampleStb = feedDuring && (m >= 3) && (m <= 8);
      sampleIn  = W'(12345 - 1000 * m);
      if (phValid !== (m == N + 3)) okT = 1'b0;
      if (m < N + 3) @(negedge clk);
    end
    markIn    = 1'b0;
    sampleStb = 1'b0;
    gotRe = int'(phRe);
    gotIm = int'(phIm);
    chkNear({tag, " R5 pulse at N+2"}, int'(okT), 1, 0);
    @(negedge clk);
    chkNear({tag, " R5 pulse one cycle"}, int'(phValid), 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; sampleIn = '0; sampleStb = 1'b0; markIn = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chkNear("R1 valid in reset", int'(phValid), 0, 0);
    chkNear("R1 re in reset", int'(phRe), 0, 0);
    chkNear("R1 im in reset", int'(phIm), 0, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkNear("R1 valid after reset", int'(phValid), 0, 0);

    // R4 and R3: nominal sweep over amplitude and phase (R11 coefficients underlie all).
    foreach (lastX[i]) lastX[i] = 0;
    for (int ai = 0; ai < 3; ai++) begin
      for (int p = 0; p < N; p++) begin
        real amp, ph;
        amp = (ai == 0) ? 1000.0 : (ai == 1) ? 12000.0 : 32767.0;
        ph  = TWO_PI * real'(p) / real'(N) + 0.3 - TWO_PI / 2.0;
        feedWave(amp, 1.0, ph);
        runMark("R4 sweep", 0, 1'b0);
        chkNear("R4 real part", gotRe, rnd(amp * $cos(ph) / SQ2), 3);
        chkNear("R4 imag part", gotIm, rnd(amp * $sin(ph) / SQ2), 3);
        if (ai == 2)
          chkNear("R3 full-scale magnitude",
                  rnd($sqrt(real'(gotRe) * gotRe + real'(gotIm) * gotIm)),
                  rnd(32767.0 / SQ2), 4);
      end
    end

    // R6: new samples without a mark leave the outputs alone.
    begin
      int holdRe, holdIm, vseen;
      holdRe = gotRe; holdIm = gotIm; vseen = 0;
      for (int k = 0; k < N; k++) begin
        sampleIn = W'(-7000 + 900 * k); sampleStb = 1'b1;
        @(negedge clk);
        if (phValid) vseen++;
      end
      sampleStb = 1'b0;
      chkNear("R6 no pulse without mark", vseen, 0, 0);
      chkNear("R6 real held", int'(phRe), holdRe, 0);
      chkNear("R6 imag held", int'(phIm), holdIm, 0);
    end

    // R2: older samples are flushed; only the newest N count.
    for (int k = 0; k < 6; k++) begin
      sampleIn = W'(30000); sampleStb = 1'b1;
      @(negedge clk);
    end
    feedWave(8000.0, 1.0, 1.0);
    runMark("R2 window", 0, 1'b0);
    chkNear("R2 newest window real", gotRe, rnd(8000.0 * $cos(1.0) / SQ2), 3);
    chkNear("R2 newest window imag", gotIm, rnd(8000.0 * $sin(1.0) / SQ2), 3);

    // R7 and R8: extra mark mid-run, samples arriving during the run.
    feedWave(20000.0, 1.0, -2.0);
    runMark("R7 mid-run mark", 6, 1'b1);
    chkNear("R8 real unaffected", gotRe, rnd(20000.0 * $cos(-2.0) / SQ2), 3);
    chkNear("R8 imag unaffected", gotIm, rnd(20000.0 * $sin(-2.0) / SQ2), 3);
    begin
      int vseen;
      vseen = 0;
      for (int m = 0; m < N + 4; m++) begin
        @(negedge clk);
        if (phValid) vseen++;
      end
      chkNear("R7 mid-run mark ignored", vseen, 0, 0);
    end

    // R7: mark in the output-load cycle is ignored too.
    feedWave(5000.0, 1.0, 0.7);
    runMark("R7 load-cycle mark", N + 2, 1'b0);
    begin
      int vseen;
      vseen = 0;
      for (int m = 0; m < N + 4; m++) begin
        @(negedge clk);
        if (phValid) vseen++;
      end
      chkNear("R7 load-cycle mark ignored", vseen, 0, 0);
    end

    // R9: DC input.
    for (int k = 0; k < N; k++) lastX[k] = 20000;
    for (int k = 0; k < N; k++) begin
      sampleIn = W'(20000); sampleStb = 1'b1;
      @(negedge clk);
    end
    sampleStb = 1'b0;
    runMark("R9 dc", 0, 1'b0);
    chkNear("R9 dc real", gotRe, 0, 2);
    chkNear("R9 dc imag", gotIm, 0, 2);

    // R10: off-nominal input, compared with the sum and with the true phasor.
    feedWave(20000.0, 1.1, 0.4);
    runMark("R10 off-nominal", 0, 1'b0);
    dftOfWindow();
    chkNear("R10 real matches sum", gotRe, rnd(expRe), 3);
    chkNear("R10 imag matches sum", gotIm, rnd(expIm), 3);
    begin
      real dr, di;
      dr = real'(gotRe) - 20000.0 * $cos(0.4) / SQ2;
      di = real'(gotIm) - 20000.0 * $sin(0.4) / SQ2;
      chkNear("R10 no correction applied",
              int'($sqrt(dr * dr + di * di) > 100.0), 1, 0);
    end

    // R10: an arbitrary ramp window checked against the sum.
    for (int k = 0; k < N; k++) begin
      lastX[k]  = -15000 + 1900 * k;
      sampleIn  = W'(lastX[k]); sampleStb = 1'b1;
      @(negedge clk);
    end
    sampleStb = 1'b0;
    runMark("R10 ramp", 0, 1'b0);
    dftOfWindow();
    chkNear("R10 ramp real", gotRe, rnd(expRe), 3);
    chkNear("R10 ramp imag", gotIm, rnd(expIm), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule